// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a byte-wide down counter driven through a power-of-two prescaler. It is controlled through a small register port with two byte registers, a count register and a control register. Software picks one of eight prescaler taps, from divide-by-1 to divide-by-128. It can load and read the count and can mask the interrupt. Each time the count steps down past zero it wraps to all ones and raises a flag. The flag stays set until software clears it, and it drives an interrupt request while unmasked.

The clock source for the prescaler is a synchronous enable, `src_en`. Tie it high to count every clock, or drive it with a one-cycle pulse per external event. A 7-bit accumulator advances on each enabled cycle. The selected tap fires a one-cycle step when the lower `tap` bits of the accumulator are all ones. The flag is held in a two-state machine:
- `FLAG_IDLE` moves to `FLAG_PENDING` on a wrap.
- `FLAG_PENDING` returns to `FLAG_IDLE` on a clearing write that does not coincide with a wrap.

Top module: `ivtimer`

## Requirements
- R1: After reset the count register reads 0xFF, the control register reads 0x44 (mask set, tap 4 = divide-by-16, flag clear), and `irq` is low.
- R2: The count register is at offset 0x8 and the control register at 0x9. In the control register, bit 7 is the flag, bit 6 is the mask, bits 2:0 are the tap, and bits 5:3 read 0. Any other offset reads 0x00, and a write to it changes nothing.
- R3: The count drops by exactly one once every 2^tap enabled source cycles and holds its value otherwise.
- R4: While `src_en` is low, neither the prescaler nor the count advances.
- R5: A step taken at count 0x00 gives 0xFF and sets the flag on that same clock edge.
- R6: A control write with bit 7 = 0 clears the flag, and one with bit 7 = 1 leaves it unchanged. If a wrap and a clearing write fall on the same edge, the flag ends up set.
- R7: `irq` is high exactly when the flag is set and the mask is clear.
- R8: A count-register write loads the count and restarts the prescaler, so the first step comes 2^tap enabled cycles after the write edge. The load takes priority over a step on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 1 | Synchronous count-source enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the wrap from 0x00 to 0xFF. A design that wrapped without flagging, or flagged one edge late, would show a wrong control byte straight after the wrap. It times the first step after a reload at divide-by-1 and divide-by-128. A prescaler left running across the load would step early. It puts a clearing write on the same edge as a wrap, where a design with the wrong priority would drop the event. It also writes 1 to the flag bit, writes to unmapped offsets, and holds the source enable low. An ungated prescaler, a flag that can be written to 1, or loose address decoding would then show up in the read data.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int IVT_CNT_W    = 8;
    localparam int IVT_PRE_W    = 7;
    localparam int IVT_SEL_W    = 3;
    localparam int IVT_ADDR_W   = 4;
    localparam int IVT_DATA_OFS = 8;
    localparam int IVT_CTRL_OFS = 9;
    localparam int IVT_TAP_RST  = 4;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_t;
endpackage

// File: rtl/ivt_prescale.sv
module ivt_prescale #(
    parameter int PRE_W = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_en,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NTAP = PRE_W + 1;

    logic [PRE_W-1:0] acc_q;
    logic [NTAP-1:0]  tap_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_q <= '0;
        else if (restart) acc_q <= '0;
        else if (src_en)  acc_q <= acc_q + 1'b1;
    end

    assign tap_hit[0] = 1'b1;
    for (genvar g = 1; g < NTAP; g++) begin : g_tap
        assign tap_hit[g] = &acc_q[g-1:0];
    end

    assign tick = src_en & tap_hit[sel];
endmodule

// File: rtl/ivt_downcount.sv
module ivt_downcount #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '1;
        else if (load) cnt_q <= load_val;
        else if (step) cnt_q <= cnt_q - 1'b1;
    end

    assign cnt  = cnt_q;
    assign wrap = step & ~load & (cnt_q == '0);
endmodule

// File: rtl/ivt_flag.sv
module ivt_flag
    import ivt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    input  logic mask,
    output logic flag,
    output logic irq
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:    if (set_evt)             state_d = FLAG_PENDING;
            FLAG_PENDING: if (clr_req && !set_evt) state_d = FLAG_IDLE;
            default:                               state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_PENDING);
        irq  = flag & ~mask;
    end
endmodule

// File: rtl/ivtimer.sv
module ivtimer
    import ivt_pkg::*;
#(
    parameter int CNT_W    = IVT_CNT_W,
    parameter int PRE_W    = IVT_PRE_W,
    parameter int SEL_W    = IVT_SEL_W,
    parameter int ADDR_W   = IVT_ADDR_W,
    parameter int DATA_OFS = IVT_DATA_OFS,
    parameter int CTRL_OFS = IVT_CTRL_OFS,
    parameter int TAP_RST  = IVT_TAP_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int FLAG_BIT = CNT_W - 1;
    localparam int MASK_BIT = CNT_W - 2;
    localparam int PAD_W    = CNT_W - 2 - SEL_W;

    logic             hit_data, hit_ctrl;
    logic             wr_data, wr_ctrl;
    logic             mask_q;
    logic [SEL_W-1:0] tap_q;
    logic             pre_tick;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_wrap;
    logic             flag_q;

    assign hit_data = (bus_addr == ADDR_W'(DATA_OFS));
    assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));
    assign wr_data  = bus_we & hit_data;
    assign wr_ctrl  = bus_we & hit_ctrl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
            tap_q  <= SEL_W'(TAP_RST);
        end else if (wr_ctrl) begin
            mask_q <= bus_wdata[MASK_BIT];
            tap_q  <= bus_wdata[SEL_W-1:0];
        end
    end

    ivt_prescale #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_en  (src_en),
        .restart (wr_data),
        .sel     (tap_q),
        .tick    (pre_tick)
    );

    ivt_downcount #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_data),
        .load_val (bus_wdata),
        .step     (pre_tick),
        .cnt      (cnt_q),
        .wrap     (cnt_wrap)
    );

    ivt_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (cnt_wrap),
        .clr_req (wr_ctrl & ~bus_wdata[FLAG_BIT]),
        .mask    (mask_q),
        .flag    (flag_q),
        .irq     (irq)
    );

    always_comb begin
        if (hit_data)      bus_rdata = cnt_q;
        else if (hit_ctrl) bus_rdata = {flag_q, mask_q, {PAD_W{1'b0}}, tap_q};
        else               bus_rdata = '0;
    end
endmodule

// File: rtl/ivtimer_chk.sv
module ivtimer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         src_en,
    input logic         load,
    input logic         ctrl_wr,
    input logic [W-1:0] wdata,
    input logic         tick,
    input logic [W-1:0] cnt,
    input logic         flag,
    input logic         mask,
    input logic         irq
);
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !src_en |-> !tick);

    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt == '0) |=> (cnt == '1 && flag));

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(ctrl_wr && !wdata[W-1])) |=> flag);

    a_r6_noset: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !(tick && !load && cnt == '0)) |=> !flag);

    a_r7_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && !mask));

    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(wdata)));
endmodule

bind ivtimer ivtimer_chk #(.W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_en  (src_en),
    .load    (wr_data),
    .ctrl_wr (wr_ctrl),
    .wdata   (bus_wdata),
    .tick    (pre_tick),
    .cnt     (cnt_q),
    .flag    (flag_q),
    .mask    (mask_q),
    .irq     (irq)
);

// File: tb/ivtimer_tb_top.sv
`timescale 1ns/1ps
module ivtimer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = 4'h8;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ivtimer dut_i (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // reference model built from the requirements
    logic [6:0] m_pre;
    logic [7:0] m_cnt;
    logic       m_flag, m_mask;
    logic [2:0] m_tap;

    function automatic logic [6:0] tap_mask(input logic [2:0] t);
        return 7'((1 << t) - 1);
    endfunction

    function automatic logic [7:0] model_read(input logic [3:0] a);
        if (a == 4'h8) return m_cnt;
        if (a == 4'h9) return {m_flag, m_mask, 3'b000, m_tap};
        return 8'h00;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre <= '0; m_cnt <= 8'hFF; m_flag <= 1'b0; m_mask <= 1'b1; m_tap <= 3'd4;
        end else begin
            logic tk, wd, wc, uf;
            tk = src_en && ((m_pre & tap_mask(m_tap)) == tap_mask(m_tap));
            wd = bus_we && bus_addr == 4'h8;
            wc = bus_we && bus_addr == 4'h9;
            uf = !wd && tk && m_cnt == 8'h00;
            m_pre <= wd ? 7'd0 : (src_en ? m_pre + 7'd1 : m_pre);
            m_cnt <= wd ? bus_wdata : (tk ? m_cnt - 8'd1 : m_cnt);
            m_flag <= uf ? 1'b1 : ((wc && !bus_wdata[7]) ? 1'b0 : m_flag);
            if (wc) begin
                m_mask <= bus_wdata[6];
                m_tap  <= bus_wdata[2:0];
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic rdchk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #750000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        step(4);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        rdchk("R1 count", 4'h8, 8'hFF);
        rdchk("R1 ctrl", 4'h9, 8'h44);
        check("R1 irq", {7'd0, irq}, 8'h00);
        // R4 source gated
        step(40);
        rdchk("R4 hold", 4'h8, 8'hFF);
        // R3 R5 tap 0
        src_en = 1'b1;
        wr(4'h9, 8'h40);
        wr(4'h8, 8'h01);
        rdchk("R8 loaded", 4'h8, 8'h01);
        step(1);
        rdchk("R3 step", 4'h8, 8'h00);
        step(1);
        rdchk("R5 wrap", 4'h8, 8'hFF);
        rdchk("R5 flag", 4'h9, 8'hC0);
        check("R7 masked", {7'd0, irq}, 8'h00);
        wr(4'h9, 8'h80);
        rdchk("R6 write1", 4'h9, 8'h80);
        check("R7 unmasked", {7'd0, irq}, 8'h01);
        wr(4'h9, 8'h00);
        rdchk("R6 clear", 4'h9, 8'h00);
        check("R7 cleared", {7'd0, irq}, 8'h00);
        // R8 full interval at divide-by-128
        wr(4'h9, 8'h47);
        wr(4'h8, 8'h10);
        step(127);
        rdchk("R8 before", 4'h8, 8'h10);
        step(1);
        rdchk("R8 first", 4'h8, 8'h0F);
        step(50);
        wr(4'h8, 8'h20);
        step(127);
        rdchk("R8 restart", 4'h8, 8'h20);
        step(1);
        rdchk("R8 restart step", 4'h8, 8'h1F);
        // R6 wrap beats clear on the same edge
        wr(4'h9, 8'h40);
        wr(4'h8, 8'h01);
        step(1);
        rdchk("R3 at zero", 4'h8, 8'h00);
        wr(4'h9, 8'h40);
        rdchk("R6 set wins", 4'h9, 8'hC0);
        // R2 unmapped offsets
        wr(4'h3, 8'h00);
        wr(4'hA, 8'h00);
        rdchk("R2 unmapped rd", 4'h3, 8'h00);
        rdchk("R2 ctrl kept", 4'h9, 8'hC0);
        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [3:0] a;
            @(negedge clk);
            r = int'($urandom % 10);
            a = (r < 4) ? 4'h8 : (r < 8) ? 4'h9 : 4'($urandom);
            bus_addr = a;
            bus_we = ($urandom % 100) < 12;
            if (a == 4'h8) bus_wdata = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 4);
            else           bus_wdata = {5'($urandom), ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 3)};
            src_en = ($urandom % 4) != 0;
            #1;
            check(a == 4'h8 ? "R3 rand count" : "R2 rand read", bus_rdata, model_read(a));
            check("R7 rand irq", {7'd0, irq}, {7'd0, m_flag & ~m_mask});
        end
        @(negedge clk);
        bus_we = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule